// File: doc/BRIEF.md
# Always-On Domain Register Write Bridge

This block sits between a fast processor-clock register bus and a bank of storage that is clocked by a slow always-on clock of about 32 kHz. The bank holds a 64-word by 32-bit retained array, one control register and three configuration registers. A bus command (write or read) is captured in a single holding register on the fast side. It is handed to the slow side with a toggle request that passes through a two-flop synchronizer. The slow side performs the command once and returns a toggle acknowledge through a second two-flop synchronizer.

Software never stalls on the bus. It issues one command, then polls `busy` or waits for the completion interrupt before it issues the next. A command that arrives while `busy` is high is dropped and recorded in a sticky error flag. Read data for a posted read is captured on the fast side in the same cycle the acknowledge lands.

Address map (7-bit address with the default sizes):

- Bit 6 low selects the retained array, with bits 5:0 as the word index.
- Bit 6 high with low bits 0 selects the control register.
- Bit 6 high with low bits 1 to 3 selects configuration registers 0 to 2.
- All other addresses are unmapped.

Top module: `slow_wr_bridge`

## Requirements
- R1: After reset `busy`, `done_raw`, `err_sticky`, `irq`, `aon_enable` and `rd_data` are all 0.
- R2: A request (`bus_req` high for one cycle) made while `busy` is low is accepted. `busy` reads 1 in the following cycle and stays 1 until the slow side's acknowledge returns, after which it falls by itself.
- R3: A request made while `busy` is high has no effect on storage, and it sets `err_sticky` in the next cycle. `err_sticky` stays set until an `err_clr` pulse.
- R4: A write (`bus_we`=1) with address bit 6 = 0 stores `bus_wdata` in array word `addr[5:0]`. A later read of that address returns it. All 64 words are independent.
- R5: A read (`bus_we`=0) is posted the same way as a write. `rd_data` takes the addressed value in the cycle `busy` falls and holds it until the next read completes.
- R6: `done_raw` becomes 1 in the same cycle that `busy` falls, and a `done_clr` pulse clears it. If the completion and `done_clr` fall in the same cycle, the completion wins and `done_raw` is 1.
- R7: `irq` is high exactly when `done_raw` and `irq_mask` are both high.
- R8: Address 64 is the control register and bit 0 is the feature enable, shown on `aon_enable`. The enable resets to 0. While it is 0, writes to the array and to the configuration registers are dropped. Writes to the control register are always committed, and reads always work.
- R9: Addresses 65, 66 and 67 are configuration registers that reset to 0 and read back what was written. Writes to other addresses with bit 6 set are dropped, and reads of them return 0.
- R10: For any ratio of the two clock frequencies, every accepted command is performed in the slow domain exactly once. No write is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Processor-side clock |
| rst_fast_n | input | 1 | Active-low reset, fast domain |
| clk_slow | input | 1 | Always-on slow clock |
| rst_slow_n | input | 1 | Active-low reset, slow domain |
| bus_req | input | 1 | One-cycle command strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Command address (see map) |
| bus_wdata | input | 32 | Write data |
| done_clr | input | 1 | Clears `done_raw` when high |
| err_clr | input | 1 | Clears `err_sticky` when high |
| irq_mask | input | 1 | Completion interrupt mask (1 = enabled) |
| busy | output | 1 | A command is in flight |
| done_raw | output | 1 | Raw completion status |
| err_sticky | output | 1 | A request was refused while busy |
| irq | output | 1 | Masked completion interrupt |
| rd_data | output | 32 | Result of the last completed read |
| aon_enable | output | 1 | Feature enable bit, slow domain |

## Verification
The completion event, driven by the returning acknowledge, and the software clear of `done_raw` can land on the same fast-clock edge. The bench provokes this by holding `done_clr` high for the whole life of a write, so the clear is present on the very edge where `busy` falls. It then expects `done_raw` to read 1 at that point and 0 one cycle later. A second overlap is a new request while the previous command is still in flight. The bench issues one during `busy` and judges it by the error flag and by a readback that shows the old word untouched.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
package swb_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } swb_op_e;

  // position of the feature enable inside the control register
  localparam int unsigned ENABLE_BIT = 0;
endpackage

// File: rtl/swb_sync.sv
`timescale 1ns/1ps
module swb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swb_fast_side.sv
`timescale 1ns/1ps
module swb_fast_side #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              done_clr,
  input  logic              err_clr,
  input  logic              irq_mask,
  input  logic              ack_tgl_async,
  input  logic [DATA_W-1:0] rd_res_async,
  output logic              req_tgl,
  output logic              hold_we,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              busy,
  output logic              done_raw,
  output logic              err_sticky,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data,
  output logic              accept_evt,
  output logic              ack_evt
);
  import swb_pkg::*;

  logic ack_sync, ack_seen, reject_evt;

  swb_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl_async), .q(ack_sync)
  );

  assign accept_evt = bus_req & ~busy;
  assign reject_evt = bus_req & busy;
  assign ack_evt    = ack_sync ^ ack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_seen   <= 1'b0;
      req_tgl    <= 1'b0;
      hold_we    <= 1'b0;
      hold_addr  <= '0;
      hold_data  <= '0;
      busy       <= 1'b0;
      done_raw   <= 1'b0;
      err_sticky <= 1'b0;
      rd_data    <= '0;
    end else begin
      ack_seen <= ack_sync;
      if (accept_evt) begin
        req_tgl   <= ~req_tgl;
        hold_we   <= bus_we;
        hold_addr <= bus_addr;
        hold_data <= bus_wdata;
        busy      <= 1'b1;
      end else if (ack_evt) begin
        busy <= 1'b0;
      end
      // slow-side result is quasi-static once the acknowledge is seen
      if (ack_evt && hold_we == OP_READ) rd_data <= rd_res_async;
      // completion wins over a simultaneous clear
      if (ack_evt)       done_raw <= 1'b1;
      else if (done_clr) done_raw <= 1'b0;
      if (reject_evt)    err_sticky <= 1'b1;
      else if (err_clr)  err_sticky <= 1'b0;
    end
  end

  assign irq = done_raw & irq_mask;
endmodule

// File: rtl/swb_slow_side.sv
`timescale 1ns/1ps
module swb_slow_side #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int NUM_CFG   = 3,
  parameter int STAGES    = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_tgl_async,
  input  logic                              cmd_we,
  input  logic [$clog2(MEM_WORDS):0]        cmd_addr,
  input  logic [DATA_W-1:0]                 cmd_data,
  output logic                              ack_tgl,
  output logic [DATA_W-1:0]                 rd_res,
  output logic                              aon_enable,
  output logic                              commit_evt
);
  import swb_pkg::*;

  localparam int IDX_W  = $clog2(MEM_WORDS);
  localparam int ADDR_W = IDX_W + 1;

  function automatic logic hits_mem(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1] == 1'b0;
  endfunction

  function automatic logic hits_ctrl(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1] && (a[IDX_W-1:0] == '0);
  endfunction

  function automatic logic hits_cfg(input logic [ADDR_W-1:0] a, input int k);
    return a[ADDR_W-1] && (a[IDX_W-1:0] == IDX_W'(k + 1));
  endfunction

  logic [DATA_W-1:0]              mem [MEM_WORDS];
  logic [DATA_W-1:0]              ctrl_q;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic [NUM_CFG-1:0]             cfg_hit;
  logic                           req_sync, req_seen;
  logic                           wr_go, feat_on;
  logic [DATA_W-1:0]              rd_mux;

  swb_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl_async), .q(req_sync)
  );

  assign commit_evt = req_sync ^ req_seen;
  assign wr_go      = commit_evt & (cmd_we == OP_WRITE);
  assign feat_on    = ctrl_q[ENABLE_BIT];
  assign aon_enable = feat_on;

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg_dec
    assign cfg_hit[k] = hits_cfg(cmd_addr, k);
  end

  always_comb begin
    rd_mux = '0;
    if (hits_mem(cmd_addr))       rd_mux = mem[cmd_addr[IDX_W-1:0]];
    else if (hits_ctrl(cmd_addr)) rd_mux = ctrl_q;
    for (int k = 0; k < NUM_CFG; k++)
      if (cfg_hit[k]) rd_mux = cfg_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      rd_res   <= '0;
      ctrl_q   <= '0;
      cfg_q    <= '0;
    end else begin
      req_seen <= req_sync;
      if (commit_evt) begin
        ack_tgl <= ~ack_tgl;
        if (cmd_we == OP_READ) rd_res <= rd_mux;
      end
      if (wr_go && hits_ctrl(cmd_addr)) ctrl_q <= cmd_data;
      for (int k = 0; k < NUM_CFG; k++)
        if (wr_go && feat_on && cfg_hit[k]) cfg_q[k] <= cmd_data;
    end
  end

  // retained array: no reset, contents survive
  always_ff @(posedge clk) begin
    if (wr_go && feat_on && hits_mem(cmd_addr))
      mem[cmd_addr[IDX_W-1:0]] <= cmd_data;
  end
endmodule

// File: rtl/slow_wr_bridge.sv
`timescale 1ns/1ps
module slow_wr_bridge #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int NUM_CFG   = 3,
  parameter int STAGES    = 2,
  localparam int ADDR_W   = $clog2(MEM_WORDS) + 1
) (
  input  logic              clk_fast,
  input  logic              rst_fast_n,
  input  logic              clk_slow,
  input  logic              rst_slow_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              done_clr,
  input  logic              err_clr,
  input  logic              irq_mask,
  output logic              busy,
  output logic              done_raw,
  output logic              err_sticky,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data,
  output logic              aon_enable
);
  logic              req_tgl, ack_tgl;
  logic              hold_we;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] rd_res;
  logic              accept_evt, ack_evt, commit_evt;

  swb_fast_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_fast (
    .clk(clk_fast), .rst_n(rst_fast_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done_clr(done_clr), .err_clr(err_clr), .irq_mask(irq_mask),
    .ack_tgl_async(ack_tgl), .rd_res_async(rd_res),
    .req_tgl(req_tgl), .hold_we(hold_we), .hold_addr(hold_addr), .hold_data(hold_data),
    .busy(busy), .done_raw(done_raw), .err_sticky(err_sticky), .irq(irq),
    .rd_data(rd_data), .accept_evt(accept_evt), .ack_evt(ack_evt)
  );

  swb_slow_side #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS), .NUM_CFG(NUM_CFG),
                  .STAGES(STAGES)) u_slow (
    .clk(clk_slow), .rst_n(rst_slow_n),
    .req_tgl_async(req_tgl), .cmd_we(hold_we), .cmd_addr(hold_addr), .cmd_data(hold_data),
    .ack_tgl(ack_tgl), .rd_res(rd_res), .aon_enable(aon_enable), .commit_evt(commit_evt)
  );
endmodule

// File: rtl/swb_checker.sv
`timescale 1ns/1ps
module swb_checker (
  input logic clk_fast,
  input logic rst_fast_n,
  input logic clk_slow,
  input logic rst_slow_n,
  input logic bus_req,
  input logic busy,
  input logic done_raw,
  input logic err_sticky,
  input logic accept_evt,
  input logic ack_evt,
  input logic commit_evt
);
  // R2: an accepted command raises busy on the next edge
  a_r2_accept_sets_busy: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    accept_evt |=> busy);

  // R2: busy only drops when the acknowledge arrives
  a_r2_busy_holds: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    (busy && !ack_evt) |=> busy);

  // R3: a request during busy is flagged
  a_r3_reject_flags: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    (bus_req && busy) |=> err_sticky);

  // R6: completion status accompanies the fall of busy
  a_r6_done_on_fall: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    $fell(busy) |-> done_raw);

  // R10: an acknowledge only ever answers an outstanding command
  a_r10_ack_when_busy: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    ack_evt |-> busy);

  // R10: a command is performed once in the slow domain
  a_r10_single_commit: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    commit_evt |=> !commit_evt);
endmodule

bind slow_wr_bridge swb_checker u_chk (
  .clk_fast(clk_fast), .rst_fast_n(rst_fast_n),
  .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
  .bus_req(bus_req), .busy(busy), .done_raw(done_raw), .err_sticky(err_sticky),
  .accept_evt(accept_evt), .ack_evt(ack_evt), .commit_evt(commit_evt)
);

// File: tb/sim_slow_wr_bridge.sv
`timescale 1ns/1ps
module sim_slow_wr_bridge;
  localparam int DW = 32;
  localparam int AW = 7;
  localparam int NV = 21;

  // {we, addr, data, expected read}
  localparam logic [71:0] TBL [NV] = '{
    {1'b1, 7'd64, 32'h0000_0001, 32'h0},
    {1'b1, 7'd0,  32'hA5A5_0001, 32'h0},
    {1'b1, 7'd63, 32'h1234_5678, 32'h0},
    {1'b1, 7'd65, 32'hCAFE_0001, 32'h0},
    {1'b1, 7'd67, 32'h0BAD_F00D, 32'h0},
    {1'b1, 7'd1,  32'h0000_1111, 32'h0},
    {1'b0, 7'd0,  32'h0,         32'hA5A5_0001},
    {1'b0, 7'd63, 32'h0,         32'h1234_5678},
    {1'b0, 7'd65, 32'h0,         32'hCAFE_0001},
    {1'b0, 7'd67, 32'h0,         32'h0BAD_F00D},
    {1'b0, 7'd64, 32'h0,         32'h0000_0001},
    {1'b1, 7'd70, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 7'd70, 32'h0,         32'h0},
    {1'b1, 7'd64, 32'h0,         32'h0},
    {1'b1, 7'd1,  32'hDEAD_BEEF, 32'h0},
    {1'b1, 7'd66, 32'h7777_7777, 32'h0},
    {1'b0, 7'd1,  32'h0,         32'h0000_1111},
    {1'b0, 7'd66, 32'h0,         32'h0},
    {1'b0, 7'd64, 32'h0,         32'h0},
    {1'b1, 7'd64, 32'h0000_0001, 32'h0},
    {1'b0, 7'd64, 32'h0,         32'h0000_0001}
  };

  logic clk_fast = 0, clk_slow = 0, rst_fast_n = 0, rst_slow_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic done_clr = 0, err_clr = 0, irq_mask = 0;
  logic busy, done_raw, err_sticky, irq, aon_enable;
  logic [DW-1:0] rd_data;
  int n_chk = 0, n_bad = 0;
  int slow_half = 35;

  always #10 clk_fast = ~clk_fast;
  always begin #(slow_half) clk_slow = ~clk_slow; end

  slow_wr_bridge u0 (
    .clk_fast(clk_fast), .rst_fast_n(rst_fast_n), .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done_clr(done_clr), .err_clr(err_clr), .irq_mask(irq_mask),
    .busy(busy), .done_raw(done_raw), .err_sticky(err_sticky), .irq(irq),
    .rd_data(rd_data), .aon_enable(aon_enable)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk_fast);
      guard++;
    end
    if (busy) chk("R2 busy never fell", 32'(busy), 32'h0);
  endtask

  task automatic post(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit see_busy);
    @(negedge clk_fast);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk_fast);
    bus_req = 0;
    if (see_busy) chk("R2 busy after accept", 32'(busy), 32'h1);
    wait_idle();
  endtask

  task automatic pulse_done_clr();
    @(negedge clk_fast); done_clr = 1;
    @(negedge clk_fast); done_clr = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int i);
    return {8'(r), 8'(i), 16'(r * 131 + i * 7)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_fast);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_fast);
    rst_fast_n = 1; rst_slow_n = 1;
    @(negedge clk_fast);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 done_raw", 32'(done_raw), 32'h0);
    chk("R1 err_sticky", 32'(err_sticky), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 aon_enable", 32'(aon_enable), 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);

    // table walk: R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [71:0] e;
      e = TBL[v];
      post(e[71], e[70:64], e[63:32], 1'b1);
      chk("R6 done after command", 32'(done_raw), 32'h1);
      if (!e[71]) chk($sformatf("R5 R4 R8 R9 table read %0d", v), rd_data, e[31:0]);
      pulse_done_clr();
      chk("R6 done cleared", 32'(done_raw), 32'h0);
    end

    // R8 enable mirrors control bit 0
    post(1'b1, 7'd64, 32'h0, 1'b0);
    chk("R8 enable off", 32'(aon_enable), 32'h0);
    post(1'b1, 7'd64, 32'h1, 1'b0);
    chk("R8 enable on", 32'(aon_enable), 32'h1);

    // R6 completion and clear in the same cycle
    @(negedge clk_fast); done_clr = 1;
    post(1'b1, 7'd5, 32'h5555_0005, 1'b0);
    chk("R6 set wins over clear", 32'(done_raw), 32'h1);
    @(negedge clk_fast);
    chk("R6 clear next cycle", 32'(done_raw), 32'h0);
    done_clr = 0;

    // R7 mask gating
    irq_mask = 0;
    post(1'b1, 7'd6, 32'h6666_0006, 1'b0);
    #1 chk("R7 masked", 32'(irq), 32'h0);
    irq_mask = 1;
    #1 chk("R7 unmasked", 32'(irq), 32'h1);
    pulse_done_clr();
    #1 chk("R7 follows done", 32'(irq), 32'h0);
    irq_mask = 0;

    // R3 request during busy
    post(1'b1, 7'd2, 32'h2222_2222, 1'b0);
    @(negedge clk_fast);
    bus_req = 1; bus_we = 1; bus_addr = 7'd2; bus_wdata = 32'h3333_3333;
    @(negedge clk_fast);
    bus_req = 0;
    chk("R3 busy during overlap", 32'(busy), 32'h1);
    bus_req = 1; bus_wdata = 32'h9999_9999;
    @(negedge clk_fast);
    bus_req = 0;
    chk("R3 err set", 32'(err_sticky), 32'h1);
    wait_idle();
    post(1'b0, 7'd2, 32'h0, 1'b0);
    chk("R3 refused write dropped", rd_data, 32'h3333_3333);
    chk("R3 err still set", 32'(err_sticky), 32'h1);
    @(negedge clk_fast); err_clr = 1;
    @(negedge clk_fast); err_clr = 0;
    chk("R3 err cleared", 32'(err_sticky), 32'h0);

    // R10 R4 all words across clock ratios
    for (int r = 0; r < 4; r++) begin
      slow_half = (r == 0) ? 7 : (r == 1) ? 35 : (r == 2) ? 97 : 233;
      for (int i = 0; i < 64; i++) post(1'b1, 7'(i), pat(r, i), 1'b0);
      for (int i = 0; i < 64; i++) begin
        post(1'b0, 7'(i), 32'h0, 1'b0);
        chk($sformatf("R10 R4 ratio %0d word %0d", r, i), rd_data, pat(r, i));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule